// File: doc/BRIEF.md
# Adaptive DC Offset Removal Loop

This block takes a stream of signed 11-bit converter samples, at most one per clock, and removes a slowly drifting DC component. A first-order feedback loop integrates the corrected output. The integer part of that running sum is the offset estimate, and the estimate is subtracted from every incoming sample. Because the loop drives the mean of its own output toward zero, a constant offset on the input fades from the output with an exponential time constant.

Three configuration inputs control the loop. One enables the correction, one freezes the estimate, and a 4-bit code selects the loop time constant as a power of two of clock cycles. The estimate is read back on its own port. The correction range is bounded by a parameter given in LSBs, and the corrected output clamps to the sample range instead of wrapping. The base exponent is a parameter, so a bench can run the loop at a practical speed.

Top module: `dcoc_loop`

## Requirements
- R1: After reset, out_valid is 0, out_sample is 0 and est_value is 0. The correction is off until cfg_enable is set.
- R2: While cfg_enable is 0, each valid sample appears unchanged on out_sample one clock later, and the estimate is held at 0.
- R3: out_valid equals in_valid delayed by one clock. A clock without in_valid leaves the estimate unchanged.
- R4: While enabled, a valid sample x yields out_sample = x − E one clock later. E is est_value before that clock, and E is the floor of the accumulator divided by 2^(BASE_EXP+11).
- R5: While enabled and not frozen, each valid sample adds its corrected value y, scaled by 2^−(BASE_EXP+code), to the estimate.
- R6: Codes 0 through 11 give time constants of 2^(BASE_EXP+code) clocks, and the time constant doubles with each code step.
- R7: Codes 12 through 15 behave exactly like code 11.
- R8: While cfg_freeze is 1, the estimate does not change, and it is still subtracted from every valid sample.
- R9: The estimate saturates at +LIMIT_LSB and at −LIMIT_LSB and does not wrap.
- R10: The corrected output saturates to the range −1024 to +1023.
- R11: With a constant input c, where |c| ≤ LIMIT_LSB, the estimate settles at exactly c and the output settles at 0.
- R12: A change of cfg_tc takes effect on the next clock and does not alter the accumulated estimate.
- R13: Clearing cfg_enable clears the accumulator. Setting it again restarts the estimate from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enables the offset correction |
| cfg_freeze | input | 1 | Holds the current estimate |
| cfg_tc | input | 4 | Time-constant code |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW (11) | Signed input sample |
| out_valid | output | 1 | Output strobe |
| out_sample | output | DW (11) | Signed corrected sample |
| est_value | output | DW (11) | Signed integer offset estimate |

## Verification
The assertions check the following on every clock: the one-cycle valid delay, pass-through and a zero estimate while disabled, the estimate holding still during freeze and idle clocks, the estimate staying within its bound, and an output clamp whenever the difference leaves the sample range. Only the bench scenarios can show the properties that need a sequence of samples. These are the exact step size per code, the doubling between codes, reserved codes matching code 11, convergence of a constant offset to a zero output, and the estimate surviving a code change. The bench checks them against an arithmetic model that scales by multiplication instead of shifting.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;
  localparam int MAX_CODE = 11;
  typedef logic [3:0] tc_code_t;

  // Map any 4-bit code onto the valid range; reserved codes act as slowest.
  function automatic tc_code_t limit_code(input tc_code_t code);
    return (code > tc_code_t'(MAX_CODE)) ? tc_code_t'(MAX_CODE) : code;
  endfunction

  // Left shift applied to the corrected sample inside the accumulator,
  // which carries BASE_EXP + MAX_CODE fraction bits.
  function automatic logic [3:0] code_to_lshift(input tc_code_t eff);
    return 4'(MAX_CODE) - eff;
  endfunction
endpackage

// File: rtl/dcoc_tc_decode.sv
module dcoc_tc_decode
  import dcoc_pkg::*;
(
  input  logic [3:0] tc_code,
  output logic [3:0] tc_eff,
  output logic [3:0] lshift,
  output logic       tc_reserved
);
  assign tc_eff      = limit_code(tc_code);
  assign lshift      = code_to_lshift(tc_eff);
  assign tc_reserved = (tc_code > 4'(MAX_CODE));
endmodule

// File: rtl/dcoc_correct.sv
module dcoc_correct #(
  parameter int DW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic signed [DW-1:0] est,
  output logic signed [DW-1:0] corr_y,
  output logic                 corr_clip,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  localparam int EW = DW + 1;
  localparam logic signed [EW-1:0] YMAX = EW'((2 ** (DW - 1)) - 1);
  localparam logic signed [EW-1:0] YMIN = -EW'(2 ** (DW - 1));

  function automatic logic signed [DW-1:0] clamp_sample(input logic signed [EW-1:0] v);
    if (v > YMAX) return DW'(YMAX);
    if (v < YMIN) return DW'(YMIN);
    return DW'(v);
  endfunction

  logic signed [EW-1:0] diff;

  assign diff      = EW'(in_sample) - EW'(est);
  assign corr_clip = enable && ((diff > YMAX) || (diff < YMIN));
  assign corr_y    = enable ? clamp_sample(diff) : in_sample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= corr_y;
    end
  end
endmodule

// File: rtl/dcoc_estimator.sv
module dcoc_estimator #(
  parameter int DW        = 11,
  parameter int FRAC      = 31,
  parameter int ACC_W     = 44,
  parameter int LIMIT_LSB = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 freeze,
  input  logic                 upd_valid,
  input  logic [3:0]           lshift,
  input  logic signed [DW-1:0] corr_y,
  output logic signed [DW-1:0] est,
  output logic                 acc_update,
  output logic                 acc_clip
);
  localparam logic signed [ACC_W-1:0] ACC_HI = ACC_W'(LIMIT_LSB) <<< FRAC;
  localparam logic signed [ACC_W-1:0] ACC_LO = -ACC_HI;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] inc;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] nxt;

  assign acc_update = enable && !freeze && upd_valid;
  assign inc        = ACC_W'(corr_y) <<< lshift;
  assign sum        = acc_q + inc;
  assign acc_clip   = acc_update && ((sum > ACC_HI) || (sum < ACC_LO));

  always_comb begin
    if (sum > ACC_HI)      nxt = ACC_HI;
    else if (sum < ACC_LO) nxt = ACC_LO;
    else                   nxt = sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          acc_q <= '0;
    else if (!enable)    acc_q <= '0;
    else if (acc_update) acc_q <= nxt;
  end

  assign est = DW'(acc_q >>> FRAC);
endmodule

// File: rtl/dcoc_loop.sv
module dcoc_loop
  import dcoc_pkg::*;
#(
  parameter int DW        = 11,
  parameter int BASE_EXP  = 20,
  parameter int LIMIT_LSB = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic                 cfg_freeze,
  input  logic [3:0]           cfg_tc,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample,
  output logic signed [DW-1:0] est_value
);
  localparam int FRAC  = BASE_EXP + MAX_CODE;
  localparam int ACC_W = DW + FRAC + 2;

  logic [3:0]           tc_eff;
  logic [3:0]           lshift;
  logic                 tc_reserved;
  logic signed [DW-1:0] est;
  logic signed [DW-1:0] corr_y;
  logic                 corr_clip;
  logic                 acc_update;
  logic                 acc_clip;

  dcoc_tc_decode u_tc (
    .tc_code    (cfg_tc),
    .tc_eff     (tc_eff),
    .lshift     (lshift),
    .tc_reserved(tc_reserved)
  );

  dcoc_correct #(.DW(DW)) u_corr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .est       (est),
    .corr_y    (corr_y),
    .corr_clip (corr_clip),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );

  dcoc_estimator #(
    .DW(DW), .FRAC(FRAC), .ACC_W(ACC_W), .LIMIT_LSB(LIMIT_LSB)
  ) u_est (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .freeze    (cfg_freeze),
    .upd_valid (in_valid),
    .lshift    (lshift),
    .corr_y    (corr_y),
    .est       (est),
    .acc_update(acc_update),
    .acc_clip  (acc_clip)
  );

  assign est_value = est;
endmodule

// File: rtl/dcoc_loop_chk.sv
module dcoc_loop_chk #(
  parameter int DW        = 11,
  parameter int LIMIT_LSB = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_enable,
  input logic                 cfg_freeze,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_sample,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample,
  input logic signed [DW-1:0] est_value,
  input logic                 acc_update,
  input logic                 corr_clip
);
  localparam logic signed [DW-1:0] SMAX = DW'((2 ** (DW - 1)) - 1);
  localparam logic signed [DW-1:0] SMIN = -DW'(2 ** (DW - 1));

  assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_enable) && !$past(in_valid) |-> $stable(est_value));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) && !$past(cfg_enable) |-> (out_sample == $past(in_sample)));

  assert_disabled_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_enable) |-> (est_value == '0));

  assert_freeze_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_enable) && $past(cfg_freeze) |-> $stable(est_value));

  assert_no_update_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_freeze |-> !acc_update);

  assert_est_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (est_value <= LIMIT_LSB) && (est_value >= -LIMIT_LSB));

  assert_out_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    corr_clip && in_valid |=> (out_sample == SMAX) || (out_sample == SMIN));
endmodule

bind dcoc_loop dcoc_loop_chk #(.DW(DW), .LIMIT_LSB(LIMIT_LSB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_enable(cfg_enable),
  .cfg_freeze(cfg_freeze),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .out_valid (out_valid),
  .out_sample(out_sample),
  .est_value (est_value),
  .acc_update(acc_update),
  .corr_clip (corr_clip)
);

// File: tb/dcoc_loop_bench.sv
`timescale 1ns/1ps
module dcoc_loop_bench;
  localparam int DW    = 11;
  localparam int BASE  = 2;
  localparam int LIM   = 40;
  localparam int FRACM = BASE + 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0;
  logic cfg_freeze = 1'b0;
  logic [3:0] cfg_tc = 4'd0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic out_valid;
  logic signed [DW-1:0] out_sample;
  logic signed [DW-1:0] est_value;

  always #2.5 clk = ~clk;

  dcoc_loop #(.DW(DW), .BASE_EXP(BASE), .LIMIT_LSB(LIM)) u_dcoc_loop (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_freeze(cfg_freeze),
    .cfg_tc(cfg_tc), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample), .est_value(est_value)
  );

  typedef struct { int val; string tag; } exp_t;
  exp_t sb[$];
  int total = 0;
  int bad = 0;
  longint acc_m = 0;
  bit done = 0;

  function automatic int model_est();
    return int'(acc_m >>> FRACM);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int x, input string tag);
    int y;
    int ec;
    longint hi;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = x[DW-1:0];
    if (!cfg_enable) y = x;
    else begin
      y = x - model_est();
      if (y > 1023) y = 1023;
      if (y < -1024) y = -1024;
    end
    sb.push_back('{y, tag});
    if (!cfg_enable) acc_m = 0;
    else if (!cfg_freeze) begin
      ec = (cfg_tc > 4'd11) ? 11 : int'(cfg_tc);
      hi = longint'(LIM) * (longint'(1) << FRACM);
      acc_m = acc_m + longint'(y) * (longint'(1) << (11 - ec));
      if (acc_m > hi) acc_m = hi;
      if (acc_m < -hi) acc_m = -hi;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    if (!cfg_enable) acc_m = 0;
  endtask

  task automatic set_cfg(input bit en, input bit frz, input int tc);
    @(negedge clk);
    in_valid   = 1'b0;
    cfg_enable = en;
    cfg_freeze = frz;
    cfg_tc     = tc[3:0];
    if (!en) acc_m = 0;
  endtask

  task automatic check_est(input int exp, input string tag);
    idle();
    chk(int'(est_value), exp, tag);
  endtask

  // Monitor: compare each produced sample with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 actual=unexpected_output expected=none");
      end else begin
        e = sb.pop_front();
        chk(int'(out_sample), e.val, e.tag);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    chk(int'(out_valid), 0, "R1 valid");
    chk(int'(out_sample), 0, "R1 sample");
    chk(int'(est_value), 0, "R1 est");
    rst_n = 1'b1;
    idle();

    // R2 pass-through while disabled
    push(100, "R2"); push(-300, "R2"); push(1023, "R2"); push(-1024, "R2");
    check_est(0, "R2 est");
    // R3 idle: no output
    idle(); idle();
    chk(int'(out_valid), 0, "R3 idle");

    // R5 single step at code 0: y=8 scaled by 1/4 -> est 2
    set_cfg(1, 0, 0);
    push(8, "R4");
    check_est(2, "R5 step");
    // R11 convergence of a constant offset
    for (int i = 0; i < 150; i++) push(25, "R11 out");
    check_est(25, "R11 est");
    push(25, "R11 zero");
    idle(); idle();

    // R8 freeze holds and keeps subtracting
    set_cfg(1, 1, 0);
    for (int i = 0; i < 20; i++) push(60, "R8 out");
    check_est(25, "R8 est");

    // R12 code change keeps the estimate
    set_cfg(1, 0, 3);
    check_est(25, "R12 est");
    // R6 step sizes: code 3 -> y/32, code 1 -> y/8
    push(89, "R6");
    check_est(27, "R6 code3");
    set_cfg(1, 0, 1);
    push(43, "R6");
    check_est(29, "R6 code1");

    // R13 disable clears, re-enable restarts at 0
    set_cfg(0, 0, 1);
    check_est(0, "R13 cleared");
    set_cfg(1, 0, 15);
    check_est(0, "R13 restart");
    // R7 reserved code follows code 11 in the model
    for (int i = 0; i < 60; i++) push(1000, "R7 out");
    check_est(model_est(), "R7 est");
    chk(model_est() > 0 ? 1 : 0, 1, "R7 moved");

    // R9 saturation of the estimate, both signs
    set_cfg(1, 0, 0);
    for (int i = 0; i < 80; i++) push(300, "R9 out");
    check_est(LIM, "R9 pos");
    // R10 output clamp low
    set_cfg(1, 1, 0);
    push(-1024, "R10 low");
    chk(-1024 - LIM, -1064, "R10 arith");
    set_cfg(1, 0, 0);
    for (int i = 0; i < 80; i++) push(-300, "R9 out");
    check_est(-LIM, "R9 neg");
    // R10 output clamp high
    set_cfg(1, 1, 0);
    push(1000, "R10 high");
    push(-500, "R4 frozen");
    idle(); idle();
    chk(sb.size(), 0, "R3 drained");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule